// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the timing engine of a dual-slope analog-to-digital converter. It steps the analog front end through one measurement at a time. First comes an offset-nulling phase. Then the unknown input is integrated for a fixed interval. Next a reference of the opposite sense discharges the integrator while a counter runs. Last, a recovery phase drives the integrator back across the comparator threshold. Every analog switch is driven from a registered phase, and the comparator is the only analog feedback.

All intervals are counted in clock ticks. One parameter gives the number of ticks in a millisecond, and the offset-nulling and integration lengths are given in milliseconds. A fixed one-millisecond settling interval comes before every closure of the integrator connection. The measured count is signed by the polarity seen during integration. It leaves the block as a one-cycle strobe with no back-pressure, because the analog sequence cannot pause. A consumer that is not ready loses that sample.

Top module: `dslope_seq`

## Requirements
- R1: While `rst_n` is low, `sw_az` is 1, and every other switch output and `res_valid` are 0.
- R2: The offset-nulling phase (`sw_az`=1) lasts at least AZ_MS×TICKS_PER_MS cycles. The phase ends after that interval only if `cont_run` is 1, or if a `start` pulse arrived since the phase began. Otherwise the phase holds indefinitely.
- R3: Integration drives `sw_in` alone for TICKS_PER_MS cycles. It then drives `sw_in` and `sw_int` together for exactly INT_MS×TICKS_PER_MS cycles, after which both fall.
- R4: The synchronised comparator level in the last integration cycle sets the polarity, where 1 means a positive input. A positive input selects `sw_refp` for the read phase. A negative input selects `sw_refn` for the read phase.
- R5: `res_fine` is sampled when offset nulling ends. Whenever a reference is applied, exactly one of `sw_ref_lo` (fine, `res_fine`=1) and `sw_ref_hi` (coarse) is 1. Both are 0 when no reference is applied.
- R6: The read phase applies the reference with `sw_int`=0 for TICKS_PER_MS cycles. It then closes `sw_int` and counts until the comparator, passed through two synchroniser flops, shows a change of level. The magnitude is the number of cycles spent with `sw_int` closed in the read phase, the terminating cycle included.
- R7: `res_valid` is 1 for exactly one cycle, the cycle after the terminating read cycle. In that cycle `res_count` is +magnitude and `res_neg`=0 for a positive polarity, or −magnitude and `res_neg`=1 for a negative one.
- R8: If no comparator change arrives within RD_MAX counted cycles, the read phase ends with magnitude RD_MAX and `res_ovr`=1. Otherwise `res_ovr` is 0.
- R9: After the read phase comes one cycle with no reference applied. The opposite reference is then applied for TICKS_PER_MS cycles with `sw_int`=0. After that `sw_int` closes until a comparator change, or for at most REC_LIMIT cycles, and offset nulling starts in the very next cycle.
- R10: `sw_refp` and `sw_refn` are never 1 in the same cycle or in adjacent cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-shot request pulse |
| cont_run | input | 1 | Free-running measurement enable |
| res_fine | input | 1 | 1 selects the low-voltage (fine) reference |
| comp_in | input | 1 | Asynchronous comparator output, 1 = integrator above threshold |
| sw_az | output | 1 | Offset-nulling switch group enable |
| sw_in | output | 1 | Input-to-buffer switch enable |
| sw_int | output | 1 | Buffer-to-integrator switch enable |
| sw_refp | output | 1 | Positive-reference switch pair enable |
| sw_refn | output | 1 | Negative-reference switch pair enable |
| sw_ref_lo | output | 1 | Low-voltage reference path select |
| sw_ref_hi | output | 1 | High-voltage reference path select |
| res_count | output | CNT_W+1 | Signed read-slope count |
| res_neg | output | 1 | Polarity of the result, 1 = negative |
| res_ovr | output | 1 | Read count reached RD_MAX without a comparator change |
| res_valid | output | 1 | One-cycle strobe for the result outputs |

## Verification
The properties assume that `comp_in` can be sampled and that it only moves when the integrator it models moves. They also assume that each parameter giving a duration is at least 1, with TICKS_PER_MS at least 1. The bench's comparator is a behavioural integrator that is updated on the falling clock edge from the switch outputs. It is cleared during offset nulling, so the comparator cannot change level while `sw_int` is open. `start` is pulsed only while offset nulling is in progress, and `res_fine` changes only between measurements.

// File: rtl/dslope_pkg.sv
package dslope_pkg;
  typedef enum logic [2:0] {
    PH_AZ,    // offset nulling
    PH_ISET,  // input applied, integrator open
    PH_IRUN,  // input integrated
    PH_RSET,  // read reference settling
    PH_RRUN,  // read slope counted
    PH_GAP,   // break between opposite references
    PH_CSET,  // recovery reference settling
    PH_CRUN   // recovery slope
  } phase_e;
endpackage

// File: rtl/dslope_sync.sv
module dslope_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync,
  output logic q_edge
);
  logic s1, s2, s2_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      s2_d <= 1'b0;
    end else begin
      s1   <= d_async;
      s2   <= s1;
      s2_d <= s2;
    end
  end

  assign q_sync = s2;
  assign q_edge = s2 ^ s2_d;
endmodule

// File: rtl/dslope_rdcnt.sv
module dslope_rdcnt #(
  parameter int RD_MAX = 20000,
  parameter int CNT_W  = 15,
  parameter int RES_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run,
  input  logic                    trip,
  input  logic                    neg,
  output logic                    done,
  output logic signed [RES_W-1:0] res_count,
  output logic                    res_neg,
  output logic                    res_ovr,
  output logic                    res_valid
);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(RD_MAX - 1);

  logic [CNT_W-1:0] cnt;
  logic [RES_W-1:0] mag;

  assign done = run && (trip || cnt == CNT_END);
  assign mag  = RES_W'(cnt) + RES_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      res_count <= '0;
      res_neg   <= 1'b0;
      res_ovr   <= 1'b0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      if (done) begin
        cnt       <= '0;
        res_valid <= 1'b1;
        res_ovr   <= !trip;
        res_neg   <= neg;
        res_count <= neg ? -$signed(mag) : $signed(mag);
      end else if (run) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/dslope_ctrl.sv
module dslope_ctrl
  import dslope_pkg::*;
#(
  parameter int AZ_TICKS  = 100000,
  parameter int INT_TICKS = 100000,
  parameter int SET_TICKS = 1000,
  parameter int REC_LIMIT = 40000,
  parameter int TMR_W     = 17
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cont_run,
  input  logic res_fine,
  input  logic comp_s,
  input  logic trip,
  input  logic rd_done,
  output logic rd_run,
  output logic neg,
  output logic sw_az,
  output logic sw_in,
  output logic sw_int,
  output logic sw_refp,
  output logic sw_refn,
  output logic sw_ref_lo,
  output logic sw_ref_hi
);
  localparam logic [TMR_W-1:0] AZ_END  = TMR_W'(AZ_TICKS - 1);
  localparam logic [TMR_W-1:0] INT_END = TMR_W'(INT_TICKS - 1);
  localparam logic [TMR_W-1:0] SET_END = TMR_W'(SET_TICKS - 1);
  localparam logic [TMR_W-1:0] REC_END = TMR_W'(REC_LIMIT - 1);

  phase_e           ph, ph_nx;
  logic [TMR_W-1:0] tmr;
  logic             pend, neg_q, fine_q;
  logic             go, rd_ph, rc_ph, any_ref;

  assign go = cont_run || pend;

  always_comb begin
    ph_nx = ph;
    unique case (ph)
      PH_AZ:   if (tmr == AZ_END && go) ph_nx = PH_ISET;
      PH_ISET: if (tmr == SET_END)      ph_nx = PH_IRUN;
      PH_IRUN: if (tmr == INT_END)      ph_nx = PH_RSET;
      PH_RSET: if (tmr == SET_END)      ph_nx = PH_RRUN;
      PH_RRUN: if (rd_done)             ph_nx = PH_GAP;
      PH_GAP:                           ph_nx = PH_CSET;
      PH_CSET: if (tmr == SET_END)      ph_nx = PH_CRUN;
      PH_CRUN: if (trip || tmr == REC_END) ph_nx = PH_AZ;
      default:                          ph_nx = PH_AZ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_AZ;
      tmr    <= '0;
      pend   <= 1'b0;
      neg_q  <= 1'b0;
      fine_q <= 1'b0;
    end else begin
      ph <= ph_nx;
      if (ph_nx != ph)                    tmr <= '0;
      else if (!(ph == PH_AZ && tmr == AZ_END)) tmr <= tmr + 1'b1;

      if (ph == PH_AZ && ph_nx != PH_AZ) begin
        pend   <= 1'b0;
        fine_q <= res_fine;
      end else if (start) begin
        pend <= 1'b1;
      end

      if (ph == PH_IRUN && ph_nx != PH_IRUN) neg_q <= !comp_s;
    end
  end

  assign rd_ph   = (ph == PH_RSET) || (ph == PH_RRUN);
  assign rc_ph   = (ph == PH_CSET) || (ph == PH_CRUN);
  assign any_ref = rd_ph || rc_ph;

  assign rd_run    = (ph == PH_RRUN);
  assign neg       = neg_q;
  assign sw_az     = (ph == PH_AZ);
  assign sw_in     = (ph == PH_ISET) || (ph == PH_IRUN);
  assign sw_int    = (ph == PH_IRUN) || (ph == PH_RRUN) || (ph == PH_CRUN);
  assign sw_refp   = (rd_ph && !neg_q) || (rc_ph && neg_q);
  assign sw_refn   = (rd_ph && neg_q) || (rc_ph && !neg_q);
  assign sw_ref_lo = any_ref && fine_q;
  assign sw_ref_hi = any_ref && !fine_q;
endmodule

// File: rtl/dslope_seq.sv
module dslope_seq #(
  parameter int TICKS_PER_MS = 1000,
  parameter int AZ_MS        = 100,
  parameter int INT_MS       = 100,
  parameter int RD_MAX       = 20000,
  parameter int REC_LIMIT    = 40000,
  parameter int CNT_W        = $clog2(RD_MAX + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   cont_run,
  input  logic                   res_fine,
  input  logic                   comp_in,
  output logic                   sw_az,
  output logic                   sw_in,
  output logic                   sw_int,
  output logic                   sw_refp,
  output logic                   sw_refn,
  output logic                   sw_ref_lo,
  output logic                   sw_ref_hi,
  output logic signed [CNT_W:0]  res_count,
  output logic                   res_neg,
  output logic                   res_ovr,
  output logic                   res_valid
);
  localparam int AZ_TICKS  = AZ_MS * TICKS_PER_MS;
  localparam int INT_TICKS = INT_MS * TICKS_PER_MS;
  localparam int SET_TICKS = TICKS_PER_MS;
  localparam int M1        = (AZ_TICKS > INT_TICKS) ? AZ_TICKS : INT_TICKS;
  localparam int M2        = (M1 > REC_LIMIT) ? M1 : REC_LIMIT;
  localparam int TMR_MAX   = (M2 > SET_TICKS) ? M2 : SET_TICKS;
  localparam int TMR_W     = $clog2(TMR_MAX + 1);

  logic comp_s, trip, rd_run, rd_done, neg;

  dslope_sync u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(comp_in),
    .q_sync(comp_s), .q_edge(trip)
  );

  dslope_ctrl #(
    .AZ_TICKS(AZ_TICKS), .INT_TICKS(INT_TICKS), .SET_TICKS(SET_TICKS),
    .REC_LIMIT(REC_LIMIT), .TMR_W(TMR_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cont_run(cont_run),
    .res_fine(res_fine), .comp_s(comp_s), .trip(trip), .rd_done(rd_done),
    .rd_run(rd_run), .neg(neg),
    .sw_az(sw_az), .sw_in(sw_in), .sw_int(sw_int),
    .sw_refp(sw_refp), .sw_refn(sw_refn),
    .sw_ref_lo(sw_ref_lo), .sw_ref_hi(sw_ref_hi)
  );

  dslope_rdcnt #(
    .RD_MAX(RD_MAX), .CNT_W(CNT_W), .RES_W(CNT_W + 1)
  ) u_rdcnt (
    .clk(clk), .rst_n(rst_n), .run(rd_run), .trip(trip), .neg(neg),
    .done(rd_done), .res_count(res_count), .res_neg(res_neg),
    .res_ovr(res_ovr), .res_valid(res_valid)
  );
endmodule

// File: rtl/dslope_seq_chk.sv
module dslope_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic sw_az,
  input logic sw_in,
  input logic sw_int,
  input logic sw_refp,
  input logic sw_refn,
  input logic sw_ref_lo,
  input logic sw_ref_hi,
  input logic res_valid
);
  a_r10_refs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_refp && sw_refn));

  a_r10_pos_then_gap: assert property (@(posedge clk) disable iff (!rst_n)
    sw_refp |=> !sw_refn);

  a_r10_neg_then_gap: assert property (@(posedge clk) disable iff (!rst_n)
    sw_refn |=> !sw_refp);

  a_r5_one_path: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_refp || sw_refn) |-> (sw_ref_lo ^ sw_ref_hi));

  a_r5_no_path_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_refp || sw_refn) |-> !(sw_ref_lo || sw_ref_hi));

  a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  a_r3_input_no_ref: assert property (@(posedge clk) disable iff (!rst_n)
    sw_in |-> !(sw_refp || sw_refn || sw_az));

  a_r6_settle_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_int) |-> $past(sw_in || sw_refp || sw_refn));

  a_r9_recovery_to_az: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_az) |-> $past(sw_int && (sw_refp || sw_refn)));
endmodule

bind dslope_seq dslope_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sw_az(sw_az), .sw_in(sw_in), .sw_int(sw_int),
  .sw_refp(sw_refp), .sw_refn(sw_refn), .sw_ref_lo(sw_ref_lo),
  .sw_ref_hi(sw_ref_hi), .res_valid(res_valid)
);

// File: tb/dslope_seq_bench.sv
module dslope_seq_bench;
  localparam int TPM   = 4;
  localparam int AZMS  = 3;
  localparam int INTMS = 5;
  localparam int RDMAX = 64;
  localparam int RECL  = 40;
  localparam int KREF  = 10;
  localparam int CW    = $clog2(RDMAX + 1);

  typedef struct packed {
    logic signed [15:0] vin;
    logic               fine;
    logic signed [7:0]  exp_cnt;
    logic               exp_ovr;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{16'sd7,   1'b1, 8'sd16,  1'b0},
    '{16'sd3,   1'b0, 8'sd8,   1'b0},
    '{-16'sd5,  1'b1, -8'sd13, 1'b0},
    '{-16'sd1,  1'b0, -8'sd5,  1'b0},
    '{16'sd13,  1'b1, 8'sd28,  1'b0},
    '{16'sd40,  1'b0, 8'sd64,  1'b1},
    '{16'sd0,   1'b1, -8'sd3,  1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, cont_run = 1'b0, res_fine = 1'b0, comp_in = 1'b0;
  logic sw_az, sw_in, sw_int, sw_refp, sw_refn, sw_ref_lo, sw_ref_hi;
  logic signed [CW:0] res_count;
  logic res_neg, res_ovr, res_valid;

  int errors = 0, checks = 0;
  int vin = 0, level = 0;

  always #5 clk = ~clk;

  dslope_seq #(
    .TICKS_PER_MS(TPM), .AZ_MS(AZMS), .INT_MS(INTMS),
    .RD_MAX(RDMAX), .REC_LIMIT(RECL)
  ) u_dslope_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cont_run(cont_run),
    .res_fine(res_fine), .comp_in(comp_in),
    .sw_az(sw_az), .sw_in(sw_in), .sw_int(sw_int),
    .sw_refp(sw_refp), .sw_refn(sw_refn),
    .sw_ref_lo(sw_ref_lo), .sw_ref_hi(sw_ref_hi),
    .res_count(res_count), .res_neg(res_neg),
    .res_ovr(res_ovr), .res_valid(res_valid)
  );

  // behavioural integrator and comparator
  always @(negedge clk) begin
    if (sw_az) level = 0;
    else begin
      if (sw_int && sw_in)   level = level + vin;
      if (sw_int && sw_refp) level = level - KREF;
      if (sw_int && sw_refn) level = level + KREF;
    end
    comp_in = (level > 0);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=completion");
    finish_run();
  end

  initial begin
    int n;
    @(negedge clk);
    // R1 reset state
    chk(sw_az == 1'b1, "R1 sw_az", sw_az, 1);
    chk({sw_in, sw_int, sw_refp, sw_refn, sw_ref_lo, sw_ref_hi, res_valid} == 7'b0,
        "R1 others low", {sw_in, sw_int, sw_refp, sw_refn, sw_ref_lo, sw_ref_hi, res_valid}, 0);

    // R2 nulling length in free-running mode
    cont_run = 1'b1;
    rst_n = 1'b1;
    n = 0;
    while (sw_az && n < 1000) begin @(negedge clk); n++; end
    chk(n == AZMS * TPM, "R2 nulling length", n, AZMS * TPM);
    cont_run = 1'b0;
    for (int g = 0; g < 2000 && !sw_az; g++) @(negedge clk);

    // R2 single-shot hold without start
    repeat (AZMS * TPM + 10) @(negedge clk);
    chk(sw_az == 1'b1 && sw_in == 1'b0, "R2 hold without start", sw_in, 0);

    for (int i = 0; i < NV; i++) begin
      int iset, irun, rec;
      bit pos;
      vin = int'(VECS[i].vin);
      res_fine = VECS[i].fine;
      pos = (VECS[i].vin > 0);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int g = 0; g < 2000 && !sw_in; g++) @(negedge clk);
      iset = 0;
      while (sw_in && !sw_int && iset < 1000) begin iset++; @(negedge clk); end
      irun = 0;
      while (sw_in && sw_int && irun < 1000) begin irun++; @(negedge clk); end
      chk(iset == TPM, "R3 input settle", iset, TPM);
      chk(irun == INTMS * TPM, "R3 integrate length", irun, INTMS * TPM);
      // now in read settling
      chk(sw_refp == pos && sw_refn == !pos, "R4 read reference", sw_refp, pos);
      chk(sw_ref_lo == VECS[i].fine && sw_ref_hi == !VECS[i].fine,
          "R5 reference path", sw_ref_lo, VECS[i].fine);
      chk(sw_int == 1'b0, "R6 read settle open", sw_int, 0);
      for (int g = 0; g < 2000 && !res_valid; g++) @(negedge clk);
      chk(res_count == VECS[i].exp_cnt, "R6 R7 count", res_count, VECS[i].exp_cnt);
      chk(res_neg == !pos, "R7 polarity flag", res_neg, !pos);
      chk(res_ovr == VECS[i].exp_ovr, "R8 overrange", res_ovr, VECS[i].exp_ovr);
      chk(!sw_refp && !sw_refn, "R10 gap cycle", {sw_refp, sw_refn}, 0);
      @(negedge clk);
      chk(res_valid == 1'b0, "R7 strobe width", res_valid, 0);
      chk(sw_refp == !pos && sw_refn == pos, "R9 opposite reference", sw_refn, pos);
      for (int g = 0; g < 2000 && !sw_int; g++) @(negedge clk);
      rec = 0;
      while (sw_int && rec < 1000) begin rec++; @(negedge clk); end
      chk(sw_az == 1'b1, "R9 nulling follows", sw_az, 1);
      if (VECS[i].exp_ovr)
        chk(rec == RECL, "R9 recovery timeout", rec, RECL);
      else
        chk(rec < RECL, "R9 recovery trips", rec, RECL - 1);
    end
    finish_run();
  end
endmodule